// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a 32-bit effective address to a physical address after a translation-cache miss. It does so by searching a hashed page table in memory. A request first picks one of sixteen segment registers using the top four address bits. It then hashes the page index with that segment's virtual segment ID and scans a group of eight 8-byte table entries. The scan reads one word per entry and compares it with a key built from the segment ID and the upper page-index bits. If no entry in the first group matches, the walker complements the hash and scans a second group, with a hash-select bit set in the key.

A match causes one more read, of the entry's second word. That word supplies the real page number. If the table base register is zero, or neither group holds a match, the request ends in a fault. A data access reports the fault on a data-fault pulse, with a status code and the faulting address. An instruction fetch reports it on a separate instruction-fault pulse. Memory is reached through a single-outstanding word read port: the request is held until it is acknowledged. The segment registers are loaded through a small write port, and the table base is a level input.

Top module: `hpw_walk_top`

## Requirements
- R1: While reset is asserted and just after it, `busy`, `done`, `hit`, `dfault`, `ifault` and `mem_req` are all low.
- R2: The first read of a walk is at `{tbr[31:16],16'h0} + ((h[22:10] & tbr[8:0]) << 16) + (h[9:0] << 6)`, where `h = ({7'b0,ea[27:12]} ^ vsid[22:0])` and the sum wraps at 32 bits.
- R3: Within a group, the walker reads the first word of entry 0 through entry 7, in order, at a stride of 8 bytes. It holds `mem_req` and `mem_addr` until `mem_ack`. It stops at the first matching entry and then reads the word at that entry's address + 4.
- R4: An entry matches only when its first word equals `{1'b1, vsid[23:0], sel, ea[27:22]}`. Here `sel` is 0 for the primary group and 1 for the secondary group. Any other value, including the key of the other group, is skipped.
- R5: When none of the eight primary entries match, the walker scans eight more entries. It uses the group address of R2, computed with `h` replaced by its 23-bit complement.
- R6: On a match, `done` pulses for one cycle with `hit` = 1 and `pa = {word[31:12], ea[11:0]}`, where `word` is the entry's second word.
- R7: When `tbr` is zero at the request, the walk ends in a fault without issuing any memory read.
- R8: A data-side walk (`req_fetch` = 0) that finds no entry pulses `done` and `dfault` with `hit` = 0. It sets `fault_status` to `{req_store, 1'b1}`: bit 0 means no translation and bit 1 means a store. It sets `fault_addr` to the effective address.
- R9: An instruction-side walk (`req_fetch` = 1) that finds no entry pulses `done` and `ifault` with `hit` = 0, and `dfault` stays low.
- R10: `busy` is high from the cycle after an accepted request until the cycle `done` pulses. A `req_valid` seen while `busy` is high starts no walk and causes no memory read.
- R11: The segment ID used by a walk is the value last written with `sr_we` to the segment register selected by `req_ea[31:28]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_we | input | 1 | Segment register write enable |
| sr_sel | input | 4 | Segment register index for the write |
| sr_vsid | input | 24 | Virtual segment ID written |
| tbr | input | 32 | Table base: origin in bits 31:16, size mask in bits 8:0 |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_ea | input | 32 | Effective address to translate |
| req_store | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| mem_req | output | 1 | Word read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Completion found a translation |
| pa | output | 32 | Physical address on a hit |
| dfault | output | 1 | Data-side translation fault pulse |
| ifault | output | 1 | Instruction-side translation fault pulse |
| fault_status | output | 2 | Data fault status: bit 1 store, bit 0 no translation |
| fault_addr | output | 32 | Effective address of the last data fault |

## Verification
The hardest case to reach is the complete secondary scan. It requires eight primary-group entries that all fail to match, some of them only narrowly, such as the other group's key or a key off by one page-index bit. It then requires a match or a miss at a chosen slot of the complemented group. The bench computes both group addresses and both keys itself and builds the two groups in a sparse memory model around each request. It plants decoys and duplicate keys at random slots and under random table sizes, and answers reads with random latency. The recorded read addresses are then compared against a walk derived from the same memory image.

// File: rtl/hpw_pkg.sv
package hpw_pkg;
   typedef enum logic [1:0] {
      WK_IDLE,
      WK_SCAN,
      WK_RPN,
      WK_MISS
   } walk_state_t;
endpackage

// File: rtl/hpw_segfile.sv
module hpw_segfile #(
   parameter int SEG_N          = 16,
   parameter int VSID_W         = 24,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int SEL_W         = $clog2(SEG_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [VSID_W-1:0] wr_vsid,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [VSID_W-1:0] rd_vsid
);
   logic [VSID_W-1:0] seg_q [SEG_N];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SEG_N; i++) seg_q[i] <= '0;
            end else if (wr_en) begin
               seg_q[wr_sel] <= wr_vsid;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (wr_en) seg_q[wr_sel] <= wr_vsid;
         end
      end
   endgenerate

   assign rd_vsid = seg_q[rd_sel];
endmodule

// File: rtl/hpw_group_hash.sv
module hpw_group_hash #(
   parameter int ADDR_W    = 32,
   parameter int VSID_W    = 24,
   parameter int PIDX_W    = 16,
   parameter int ORG_W     = 16,
   parameter int MASK_W    = 9,
   parameter int HASH_W    = 23,
   parameter int LOW_W     = 10,
   parameter int API_W     = 6,
   parameter int GRP_SHIFT = 6,
   localparam int HI_W     = HASH_W - LOW_W
) (
   input  logic [PIDX_W-1:0] pidx,
   input  logic [VSID_W-1:0] vsid,
   input  logic [ORG_W-1:0]  origin,
   input  logic [MASK_W-1:0] size_mask,
   input  logic              second,
   output logic [ADDR_W-1:0] group_base,
   output logic [ADDR_W-1:0] match_key
);
   logic [HASH_W-1:0] h_pri, h_use;
   logic [HI_W-1:0]   hi_bits;

   always_comb begin
      h_pri      = HASH_W'(pidx) ^ vsid[HASH_W-1:0];
      h_use      = second ? ~h_pri : h_pri;
      hi_bits    = h_use[HASH_W-1:LOW_W] & HI_W'(size_mask);
      group_base = {origin, {(ADDR_W-ORG_W){1'b0}}}
                 + (ADDR_W'(hi_bits) << (ADDR_W - ORG_W))
                 + (ADDR_W'(h_use[LOW_W-1:0]) << GRP_SHIFT);
      match_key  = {1'b1, vsid, second, pidx[PIDX_W-1 -: API_W]};
   end
endmodule

// File: rtl/hpw_walker.sv
module hpw_walker
   import hpw_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int VSID_W     = 24,
   parameter int MASK_W     = 9,
   parameter int ENTRIES    = 8,
   parameter int PAGE_SHIFT = 12,
   parameter int SEL_W      = 4,
   parameter int ORG_W      = 16,
   localparam int PIDX_W    = ADDR_W - SEL_W - PAGE_SHIFT,
   localparam int IDX_W     = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_ea,
   input  logic              start_store,
   input  logic              start_fetch,
   input  logic [VSID_W-1:0] start_vsid,
   input  logic [ADDR_W-1:0] tbr,
   output logic [PIDX_W-1:0] cur_pidx,
   output logic [VSID_W-1:0] cur_vsid,
   output logic [ORG_W-1:0]  cur_origin,
   output logic [MASK_W-1:0] cur_mask,
   output logic              cur_second,
   input  logic [ADDR_W-1:0] group_base,
   input  logic [ADDR_W-1:0] match_key,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              hit,
   output logic [ADDR_W-1:0] pa,
   output logic              dfault,
   output logic              ifault,
   output logic [1:0]        fault_status,
   output logic [ADDR_W-1:0] fault_addr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
   localparam int ENT_SHIFT = 3;

   walk_state_t       state_q;
   logic [ADDR_W-1:0] ea_q;
   logic              store_q, fetch_q;
   logic [IDX_W-1:0]  idx_q;

   assign cur_pidx = ea_q[ADDR_W-SEL_W-1:PAGE_SHIFT];
   assign busy     = (state_q != WK_IDLE);
   assign mem_req  = (state_q == WK_SCAN) || (state_q == WK_RPN);
   assign mem_addr = group_base + (ADDR_W'(idx_q) << ENT_SHIFT)
                   + ((state_q == WK_RPN) ? ADDR_W'(4) : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= WK_IDLE;
         ea_q         <= '0;
         store_q      <= 1'b0;
         fetch_q      <= 1'b0;
         idx_q        <= '0;
         cur_vsid     <= '0;
         cur_origin   <= '0;
         cur_mask     <= '0;
         cur_second   <= 1'b0;
         done         <= 1'b0;
         hit          <= 1'b0;
         pa           <= '0;
         dfault       <= 1'b0;
         ifault       <= 1'b0;
         fault_status <= '0;
         fault_addr   <= '0;
      end else begin
         done   <= 1'b0;
         dfault <= 1'b0;
         ifault <= 1'b0;
         unique case (state_q)
            WK_IDLE: if (start) begin
               ea_q       <= start_ea;
               store_q    <= start_store;
               fetch_q    <= start_fetch;
               cur_vsid   <= start_vsid;
               cur_origin <= tbr[ADDR_W-1 -: ORG_W];
               cur_mask   <= tbr[MASK_W-1:0];
               cur_second <= 1'b0;
               idx_q      <= '0;
               state_q    <= (tbr == '0) ? WK_MISS : WK_SCAN;
            end
            WK_SCAN: if (mem_ack) begin
               if (mem_rdata == match_key) begin
                  state_q <= WK_RPN;
               end else if (idx_q == LAST) begin
                  idx_q <= '0;
                  if (cur_second) state_q <= WK_MISS;
                  else cur_second <= 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            WK_RPN: if (mem_ack) begin
               done    <= 1'b1;
               hit     <= 1'b1;
               pa      <= {mem_rdata[ADDR_W-1:PAGE_SHIFT], ea_q[PAGE_SHIFT-1:0]};
               state_q <= WK_IDLE;
            end
            WK_MISS: begin
               done    <= 1'b1;
               hit     <= 1'b0;
               state_q <= WK_IDLE;
               if (fetch_q) begin
                  ifault <= 1'b1;
               end else begin
                  dfault       <= 1'b1;
                  fault_status <= {store_q, 1'b1};
                  fault_addr   <= ea_q;
               end
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hpw_walk_top.sv
module hpw_walk_top #(
   parameter int ADDR_W     = 32,
   parameter int SEG_N      = 16,
   parameter int VSID_W     = 24,
   parameter int ENTRIES    = 8,
   parameter int MASK_W     = 9,
   parameter int HASH_W     = 23,
   parameter int LOW_W      = 10,
   parameter int API_W      = 6,
   parameter int PAGE_SHIFT = 12,
   parameter int ORG_W      = 16,
   parameter bit SR_CLEAR   = 1'b1,
   localparam int SEL_W     = $clog2(SEG_N),
   localparam int PIDX_W    = ADDR_W - SEL_W - PAGE_SHIFT,
   localparam int GRP_SHIFT = $clog2(ENTRIES * 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sr_we,
   input  logic [SEL_W-1:0]  sr_sel,
   input  logic [VSID_W-1:0] sr_vsid,
   input  logic [ADDR_W-1:0] tbr,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_ea,
   input  logic              req_store,
   input  logic              req_fetch,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              hit,
   output logic [ADDR_W-1:0] pa,
   output logic              dfault,
   output logic              ifault,
   output logic [1:0]        fault_status,
   output logic [ADDR_W-1:0] fault_addr
);
   generate
      if (1 + VSID_W + 1 + API_W != ADDR_W) begin : g_bad_key
         $error("compare key fields must fill one address word");
      end
      if ((ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_group
         $error("group entry count must be a power of two");
      end
      if (MASK_W > HASH_W - LOW_W || VSID_W < HASH_W) begin : g_bad_hash
         $error("hash widths are inconsistent");
      end
      if (GRP_SHIFT + LOW_W != ADDR_W - ORG_W) begin : g_bad_org
         $error("group offset must end at the table origin alignment");
      end
   endgenerate

   logic [VSID_W-1:0] rd_vsid, cur_vsid;
   logic [PIDX_W-1:0] cur_pidx;
   logic [ORG_W-1:0]  cur_origin;
   logic [MASK_W-1:0] cur_mask;
   logic              cur_second;
   logic [ADDR_W-1:0] group_base, match_key;

   hpw_segfile #(.SEG_N(SEG_N), .VSID_W(VSID_W), .CLEAR_ON_RESET(SR_CLEAR)) u_seg (
      .clk(clk), .rst_n(rst_n), .wr_en(sr_we), .wr_sel(sr_sel), .wr_vsid(sr_vsid),
      .rd_sel(req_ea[ADDR_W-1 -: SEL_W]), .rd_vsid(rd_vsid)
   );

   hpw_group_hash #(
      .ADDR_W(ADDR_W), .VSID_W(VSID_W), .PIDX_W(PIDX_W), .ORG_W(ORG_W),
      .MASK_W(MASK_W), .HASH_W(HASH_W), .LOW_W(LOW_W), .API_W(API_W),
      .GRP_SHIFT(GRP_SHIFT)
   ) u_hash (
      .pidx(cur_pidx), .vsid(cur_vsid), .origin(cur_origin), .size_mask(cur_mask),
      .second(cur_second), .group_base(group_base), .match_key(match_key)
   );

   hpw_walker #(
      .ADDR_W(ADDR_W), .VSID_W(VSID_W), .MASK_W(MASK_W), .ENTRIES(ENTRIES),
      .PAGE_SHIFT(PAGE_SHIFT), .SEL_W(SEL_W), .ORG_W(ORG_W)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .start(req_valid), .start_ea(req_ea),
      .start_store(req_store), .start_fetch(req_fetch), .start_vsid(rd_vsid), .tbr(tbr),
      .cur_pidx(cur_pidx), .cur_vsid(cur_vsid), .cur_origin(cur_origin),
      .cur_mask(cur_mask), .cur_second(cur_second),
      .group_base(group_base), .match_key(match_key),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .hit(hit), .pa(pa), .dfault(dfault), .ifault(ifault),
      .fault_status(fault_status), .fault_addr(fault_addr)
   );
endmodule

// File: rtl/hpw_checker.sv
module hpw_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic              hit,
   input logic              dfault,
   input logic              ifault,
   input logic              mem_req,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr
);
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (!busy && !done && !mem_req && !dfault && !ifault));

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_fault_nohit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dfault || ifault) |-> (done && !hit));

   p_fault_side_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dfault, ifault}));

   p_idle_noread_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   p_done_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
endmodule

bind hpw_walk_top hpw_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
   .hit(hit), .dfault(dfault), .ifault(ifault), .mem_req(mem_req),
   .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/tb_hpw_walk_top.sv
module tb_hpw_walk_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        sr_we;
   logic [3:0]  sr_sel;
   logic [23:0] sr_vsid;
   logic [31:0] tbr;
   logic        req_valid, req_store, req_fetch;
   logic [31:0] req_ea;
   logic        mem_req, mem_ack;
   logic [31:0] mem_addr, mem_rdata;
   logic        busy, done, hit, dfault, ifault;
   logic [31:0] pa, fault_addr;
   logic [1:0]  fault_status;

   int unsigned mem [int unsigned];
   int unsigned trace [$];
   logic [23:0] sr_model [16];
   int total = 0;
   int fails = 0;
   int lat = 0;

   always #10 clk = ~clk;

   hpw_walk_top dut (
      .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_sel(sr_sel), .sr_vsid(sr_vsid),
      .tbr(tbr), .req_valid(req_valid), .req_ea(req_ea), .req_store(req_store),
      .req_fetch(req_fetch), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .hit(hit), .pa(pa),
      .dfault(dfault), .ifault(ifault), .fault_status(fault_status),
      .fault_addr(fault_addr)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   function automatic logic [31:0] ref_base(input logic [31:0] ea, input logic [23:0] v,
                                            input logic [31:0] t, input bit sec);
      logic [22:0] h;
      h = {7'b0, ea[27:12]} ^ v[22:0];
      if (sec) h = ~h;
      return {t[31:16], 16'h0} + (({19'b0, h[22:10]} & {23'b0, t[8:0]}) << 16)
           + ({22'b0, h[9:0]} << 6);
   endfunction

   function automatic logic [31:0] ref_key(input logic [31:0] ea, input logic [23:0] v,
                                           input bit sec);
      return {1'b1, v, sec, ea[27:22]};
   endfunction

   // Mem** responder: one read answered at a time, random latency.
   initial begin
      mem_ack = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_ack) mem_ack = 1'b0;
         else if (mem_req && rst_n) begin
            if (lat > 0) lat--;
            else begin
               mem_ack = 1'b1;
               mem_rdata = rd(mem_addr);
               trace.push_back(mem_addr);
               lat = int'($urandom % 3);
            end
         end
      end
   end

   task automatic set_sr(input int i, input logic [23:0] v);
      @(negedge clk);
      sr_we = 1'b1; sr_sel = 4'(i); sr_vsid = v;
      @(negedge clk);
      sr_we = 1'b0;
      sr_model[i] = v;
   endtask

   // kind 0: absent (with decoys), 1: primary slot k1, 2: secondary slot k1,
   // 3: two primary copies (first one wins)
   task automatic prep(input logic [31:0] ea, input int kind, input int k1, input int k2);
      logic [23:0] v;
      logic [31:0] pb, sb, kp, ks;
      v  = sr_model[ea[31:28]];
      pb = ref_base(ea, v, tbr, 1'b0);
      sb = ref_base(ea, v, tbr, 1'b1);
      kp = ref_key(ea, v, 1'b0);
      ks = ref_key(ea, v, 1'b1);
      mem.delete();
      for (int i = 0; i < 8; i++) begin
         mem[pb + 8*i]     = $urandom & 32'h7fff_ffff;
         mem[pb + 8*i + 4] = $urandom;
         mem[sb + 8*i]     = $urandom & 32'h7fff_ffff;
         mem[sb + 8*i + 4] = $urandom;
      end
      case (kind)
         0: begin
            mem[pb + 8*k1] = ks;        // R4: other group's key is skipped
            mem[sb + 8*k2] = kp;
            mem[pb + 8*k2] = kp ^ 32'h1;
         end
         1: begin
            mem[pb + 8*k2] = ks;
            mem[pb + 8*k1] = kp;
         end
         2: begin
            mem[pb + 8*k2] = ks;
            mem[sb + 8*((k1 + 3) % 8)] = kp ^ 32'h20;
            mem[sb + 8*k1] = ks;
         end
         default: begin
            mem[pb + 8*k1] = kp;
            mem[pb + 8*k2] = kp;
         end
      endcase
   endtask

   task automatic run_walk(input logic [31:0] ea, input bit st, input bit fe,
                           input bit poke, input string tag);
      logic [23:0] v;
      logic [31:0] a, exp_pa;
      logic [31:0] exp_reads [$];
      bit found, used_sec;
      int cnt, nrd;
      v = sr_model[ea[31:28]];
      found = 1'b0; used_sec = 1'b0; exp_pa = '0;
      if (tbr != 0) begin
         for (int s = 0; s < 2 && !found; s++) begin
            for (int i = 0; i < 8 && !found; i++) begin
               a = ref_base(ea, v, tbr, s[0]) + 32'(8*i);
               exp_reads.push_back(a);
               if (s == 1) used_sec = 1'b1;
               if (rd(a) == ref_key(ea, v, s[0])) begin
                  found = 1'b1;
                  exp_reads.push_back(a + 4);
                  exp_pa = {rd(a + 4) >> 12, ea[11:0]};
               end
            end
         end
      end
      @(negedge clk);
      trace.delete();
      req_valid = 1'b1; req_ea = ea; req_store = st; req_fetch = fe;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R10", "busy after accept", 32'(busy), 32'h1);
      if (poke && tbr != 0) begin
         req_valid = 1'b1;
         req_ea = ea ^ 32'h3000_5000;
         req_fetch = ~fe;
      end
      cnt = 0;
      do begin
         @(negedge clk);
         req_valid = 1'b0;
         cnt++;
      end while (!done && cnt < 400);
      chk(done == 1'b1, "R6", "done pulse seen", 32'(done), 32'h1);
      chk(hit == found, found ? "R6" : "R8", "hit flag", 32'(hit), 32'(found));
      if (found) begin
         chk(pa == exp_pa, "R6", "physical address", pa, exp_pa);
      end else if (fe) begin
         chk(ifault && !dfault, "R9", "fetch fault side", {30'b0, ifault, dfault}, 32'h2);
      end else begin
         chk(dfault && !ifault, "R8", "data fault side", {30'b0, ifault, dfault}, 32'h1);
         chk(fault_status == {st, 1'b1}, "R8", "fault status", 32'(fault_status),
             32'({st, 1'b1}));
         chk(fault_addr == ea, "R8", "fault address", fault_addr, ea);
      end
      nrd = trace.size();
      chk(nrd == exp_reads.size(), tbr == 0 ? "R7" : "R3", "read count",
          32'(nrd), 32'(exp_reads.size()));
      for (int i = 0; i < nrd && i < exp_reads.size(); i++) begin
         chk(trace[i] == exp_reads[i],
             (i == 0) ? tag : ((used_sec && i >= 8) ? "R5" : "R3"),
             $sformatf("read %0d address", i), trace[i], exp_reads[i]);
      end
      repeat (4) @(negedge clk);
      if (poke) begin
         chk(trace.size() == nrd && !busy, "R10", "request while busy ignored",
             32'(trace.size()), 32'(nrd));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; fails++;
      $display("FAIL R10 watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; sr_we = 1'b0; sr_sel = '0; sr_vsid = '0; tbr = '0;
      req_valid = 1'b0; req_ea = '0; req_store = 1'b0; req_fetch = 1'b0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mem_req && !hit && !dfault && !ifault, "R1",
          "outputs in reset", {26'b0, busy, done, mem_req, hit, dfault, ifault}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !mem_req, "R1", "outputs after reset",
          {29'b0, busy, done, mem_req}, 32'h0);
      for (int i = 0; i < 16; i++) set_sr(i, 24'($urandom));

      // R7: zero table base faults with no reads, on each side
      tbr = 32'h0;
      run_walk(32'h4567_8abc, 1'b0, 1'b0, 1'b0, "R7");
      run_walk(32'h4567_8abc, 1'b1, 1'b0, 1'b0, "R7");
      run_walk(32'h9000_1234, 1'b0, 1'b1, 1'b0, "R7");

      // R5: full mask, hit in last secondary slot; then complete miss
      tbr = 32'h1234_01ff;
      prep(32'h7abc_d123, 2, 7, 0);
      run_walk(32'h7abc_d123, 1'b0, 1'b0, 1'b0, "R2");
      prep(32'h7abc_d123, 0, 7, 7);
      run_walk(32'h7abc_d123, 1'b1, 1'b0, 1'b0, "R2");
      prep(32'h7abc_d123, 0, 2, 5);
      run_walk(32'h7abc_d123, 1'b0, 1'b1, 1'b0, "R2");

      // R11: two segments, same page bits, different segment IDs
      set_sr(3, 24'h0a5a5a);
      set_sr(12, 24'h35c3c3);
      prep(32'h3111_2fff, 1, 0, 4);
      run_walk(32'h3111_2fff, 1'b0, 1'b0, 1'b0, "R11");
      prep(32'hc111_2fff, 3, 1, 6);
      run_walk(32'hc111_2fff, 1'b0, 1'b0, 1'b1, "R11");

      for (int n = 0; n < 80; n++) begin
         logic [31:0] ea;
         int kind, k1, k2;
         tbr = {16'($urandom), 7'b0, 9'($urandom)};
         if (tbr == 0) tbr = 32'h0001_0000;
         ea = $urandom;
         kind = int'($urandom % 4);
         k1 = int'($urandom % 8);
         k2 = int'($urandom % 8);
         if (kind == 3 && k2 <= k1) begin k2 = 7; if (k1 == 7) k1 = 0; end
         prep(ea, kind, k1, k2);
         run_walk(ea, 1'($urandom), 1'($urandom), 1'($urandom), "R2");
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule